// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Multiplexed Address

This block accepts single-supercell read and write requests on a flat address and carries them out on a small DRAM array. The array is a grid of `ROWS x COLS` supercells of `DATA_W` bits. It is modelled inside the block, together with its row buffer. The address lines to the array are shared in time. They carry the row index while the row strobe is active and the column index while the column strobe is active. The controller splits each request address into a row field and a column field. If the row is not already in the row buffer, it opens it with a row strobe. It then moves one supercell with a column strobe.

The controller remembers which row sits in the buffer. When a request targets that same row, it skips the row strobe and issues only the column strobe. Writes land in the row buffer. The buffer is copied back into the array by a close strobe when the row is given up. A refresh timer asks for one row refresh every `REF_INTERVAL` cycles and steps through the rows in turn. A refresh first closes any open row, so no buffered write is lost.

Top module: `dramc_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, no strobe is active and the array holds all zeros.
- R2: The request address maps its upper `ROW_W` bits to the row and its lower `COL_W` bits to the column. `mem_addr` carries the row while `mem_ras` is high and the column while `mem_cas` is high.
- R3: A request issued while no row is open produces exactly one row strobe followed by one column strobe, with no close strobe.
- R4: A request to the row that is already open produces a column strobe only, with no row or close strobe.
- R5: A request to a row other than the open one produces a close strobe, then a row strobe, then a column strobe, in that order.
- R6: A read raises `rsp_valid` for one cycle, in the cycle after its column strobe. `rsp_rdata` then holds the value most recently written to that address, or zero if the address was never written.
- R7: Write data is held in the row buffer and written back to the array when the row is closed, so it survives a later switch to another row.
- R8: `req_ready` is 0 whenever a strobe sequence or a refresh is in progress. A request is taken only on a cycle where `req_valid` and `req_ready` are both 1.
- R9: A refresh, marked by `mem_refresh`, activates one row per request from the timer. The rows are visited in the order 0, 1, 2, …. Two refresh row strobes are never more than `REF_INTERVAL + 8` cycles apart.
- R10: A refresh closes the open row, writing it back first. The next request therefore issues a row strobe even if it targets the row that was open before, and data written before the refresh is still read back.
- R11: At most one of `mem_ras`, `mem_cas`, `mem_pre` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat supercell address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| mem_ras | output | 1 | Row strobe to the array |
| mem_cas | output | 1 | Column strobe to the array |
| mem_pre | output | 1 | Close strobe (row buffer write-back) |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_refresh | output | 1 | A refresh sequence is running |

## Verification
The bench keeps its own copy of which row should be open. For every request it counts close, row and column strobes, so a controller that re-opens a row it already holds, or that fails to close before switching, shows up as a strobe-count mismatch. Directed runs write a value, switch rows and read it back. A design that never writes the buffer back returns zero there. One directed run straddles a refresh: a controller that keeps its open-row flag across the refresh skips the row strobe and reads a stale buffer. A monitor tracks the refresh row order and spacing, which catches a stuck or skipped refresh row counter.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_COL  = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CLOSE  = 3'd1,
        ST_OPEN   = 3'd2,
        ST_XFER   = 3'd3,
        ST_RCLOSE = 3'd4,
        ST_ROPEN  = 3'd5,
        ST_RDONE  = 3'd6
    } state_e;

    function automatic logic is_refresh_state(state_e s);
        return (s == ST_RCLOSE) || (s == ST_ROPEN) || (s == ST_RDONE);
    endfunction

endpackage

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
    parameter int ROWS         = 4,
    parameter int REF_INTERVAL = 1000000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_done,
    output logic                    ref_due,
    output logic [$clog2(ROWS)-1:0] ref_row
);
    localparam int CW = $clog2(REF_INTERVAL + 1);

    logic [CW-1:0] tick_q;
    logic [3:0]    wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= '0;
            ref_due <= 1'b0;
            ref_row <= '0;
        end else begin
            if (tick_q == CW'(REF_INTERVAL - 1)) begin
                tick_q  <= '0;
                ref_due <= 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
                if (ref_done) ref_due <= 1'b0;
            end
            if (ref_done) ref_row <= ref_row + 1'b1;
        end
    end

    // cycles a pending refresh has waited, to bound service delay
    always_ff @(posedge clk) begin
        if (rst || !ref_due)  wait_q <= '0;
        else if (wait_q != 4'hF) wait_q <= wait_q + 1'b1;
    end

    p_due_served_r9: assert property (@(posedge clk) disable iff (rst)
        ref_due |-> (wait_q < 4'd8));

endmodule

// File: rtl/dramc_array.sv
module dramc_array #(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  dramc_pkg::cmd_e            cmd,
    input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
    input  logic                       we,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata
);
    import dramc_pkg::*;
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;
    localparam int CELLS = ROWS * COLS;

    logic [DATA_W-1:0] cells   [CELLS];
    logic [DATA_W-1:0] row_buf [COLS];
    logic              loaded_q;
    logic [ROW_W-1:0]  loaded_row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CELLS; i++) cells[i] <= '0;
            for (int c = 0; c < COLS; c++) row_buf[c] <= '0;
            loaded_q     <= 1'b0;
            loaded_row_q <= '0;
            rdata        <= '0;
        end else begin
            unique case (cmd)
                CMD_ACT: begin
                    for (int c = 0; c < COLS; c++)
                        row_buf[c] <= cells[{addr[ROW_W-1:0], COL_W'(c)}];
                    loaded_q     <= 1'b1;
                    loaded_row_q <= addr[ROW_W-1:0];
                end
                CMD_COL: begin
                    if (we) row_buf[addr[COL_W-1:0]] <= wdata;
                    else    rdata <= row_buf[addr[COL_W-1:0]];
                end
                CMD_PRE: begin
                    for (int c = 0; c < COLS; c++)
                        cells[{loaded_row_q, COL_W'(c)}] <= row_buf[c];
                    loaded_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    p_col_needs_row_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_COL) |-> loaded_q);
    p_act_needs_close_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |-> !loaded_q);
    p_pre_needs_row_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> loaded_q);

endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl #(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_we,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    input  logic                     ref_due,
    input  logic [ROW_W-1:0]         ref_row,
    output logic                     ref_done,
    output dramc_pkg::cmd_e          cmd,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
    output logic                     we,
    output logic [DATA_W-1:0]        wdata,
    output logic                     refreshing
);
    import dramc_pkg::*;
    localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;

    state_e           state_q;
    logic             q_we;
    logic [ROW_W-1:0] q_row;
    logic [COL_W-1:0] q_col;
    logic [DATA_W-1:0] q_wdata;
    logic             open_vld_q;
    logic [ROW_W-1:0] open_row_q;

    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;
    logic             accept;

    assign in_row    = req_addr[ROW_W+COL_W-1:COL_W];
    assign in_col    = req_addr[COL_W-1:0];
    assign req_ready = (state_q == ST_IDLE) && !ref_due;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            q_we       <= 1'b0;
            q_row      <= '0;
            q_col      <= '0;
            q_wdata    <= '0;
            open_vld_q <= 1'b0;
            open_row_q <= '0;
            rsp_valid  <= 1'b0;
        end else begin
            rsp_valid <= (state_q == ST_XFER) && !q_we;
            unique case (state_q)
                ST_IDLE: begin
                    if (ref_due) begin
                        state_q <= open_vld_q ? ST_RCLOSE : ST_ROPEN;
                    end else if (req_valid) begin
                        q_we    <= req_we;
                        q_row   <= in_row;
                        q_col   <= in_col;
                        q_wdata <= req_wdata;
                        if (open_vld_q && open_row_q == in_row) state_q <= ST_XFER;
                        else if (open_vld_q)                    state_q <= ST_CLOSE;
                        else                                    state_q <= ST_OPEN;
                    end
                end
                ST_CLOSE: begin
                    open_vld_q <= 1'b0;
                    state_q    <= ST_OPEN;
                end
                ST_OPEN: begin
                    open_vld_q <= 1'b1;
                    open_row_q <= q_row;
                    state_q    <= ST_XFER;
                end
                ST_XFER:   state_q <= ST_IDLE;
                ST_RCLOSE: begin
                    open_vld_q <= 1'b0;
                    state_q    <= ST_ROPEN;
                end
                ST_ROPEN:  state_q <= ST_RDONE;
                ST_RDONE:  state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd      = CMD_NONE;
        addr     = '0;
        we       = 1'b0;
        wdata    = q_wdata;
        ref_done = 1'b0;
        unique case (state_q)
            ST_CLOSE, ST_RCLOSE: cmd = CMD_PRE;
            ST_OPEN: begin
                cmd  = CMD_ACT;
                addr = AW'(q_row);
            end
            ST_XFER: begin
                cmd  = CMD_COL;
                addr = AW'(q_col);
                we   = q_we;
            end
            ST_ROPEN: begin
                cmd  = CMD_ACT;
                addr = AW'(ref_row);
            end
            ST_RDONE: begin
                cmd      = CMD_PRE;
                ref_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign refreshing = is_refresh_state(state_q);

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !req_ready);
    p_hit_skip_row_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && open_vld_q && open_row_q == in_row) |=> (cmd == CMD_COL));
    p_miss_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && !open_vld_q) |=> (cmd == CMD_ACT && addr == AW'($past(in_row))));
    p_refresh_closes_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RDONE) |=> !open_vld_q);
    p_rsp_after_col_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(cmd) == CMD_COL && !$past(we)));

endmodule

// File: rtl/dramc_top.sv
module dramc_top #(
    parameter int ROW_W        = 2,
    parameter int COL_W        = 2,
    parameter int DATA_W       = 8,
    parameter int REF_INTERVAL = 1000000,
    localparam int AW          = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   mem_ras,
    output logic                   mem_cas,
    output logic                   mem_pre,
    output logic [AW-1:0]          mem_addr,
    output logic                   mem_refresh
);
    import dramc_pkg::*;
    localparam int ROWS = 1 << ROW_W;

    logic              ref_due, ref_done;
    logic [ROW_W-1:0]  ref_row;
    cmd_e              cmd;
    logic              arr_we;
    logic [DATA_W-1:0] arr_wdata;

    dramc_refresh_timer #(.ROWS(ROWS), .REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk(clk), .rst(rst), .ref_done(ref_done),
        .ref_due(ref_due), .ref_row(ref_row)
    );

    dramc_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .ref_due(ref_due), .ref_row(ref_row), .ref_done(ref_done),
        .cmd(cmd), .addr(mem_addr), .we(arr_we), .wdata(arr_wdata),
        .refreshing(mem_refresh)
    );

    dramc_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(mem_addr),
        .we(arr_we), .wdata(arr_wdata), .rdata(rsp_rdata)
    );

    assign mem_ras = (cmd == CMD_ACT);
    assign mem_cas = (cmd == CMD_COL);
    assign mem_pre = (cmd == CMD_PRE);

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_ras, mem_cas, mem_pre}));

endmodule

// File: tb/dramc_top_tb_top.sv
module dramc_top_tb_top;
    localparam int ROW_W = 2, COL_W = 2, DATA_W = 8, REF_IV = 50;
    localparam int AW = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_ras, mem_cas, mem_pre, mem_refresh;
    logic [7:0] rsp_rdata;
    logic [AW-1:0] mem_addr;

    int total = 0, bad = 0;
    logic [7:0] model [16];
    logic open_vld = 1'b0;
    logic [1:0] open_row = '0;
    int ref_expect = 0, ref_gap = 0, ref_seen = 0;
    logic in_ref = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dramc_top #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REF_INTERVAL(REF_IV)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ras(mem_ras),
        .mem_cas(mem_cas), .mem_pre(mem_pre), .mem_addr(mem_addr),
        .mem_refresh(mem_refresh)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // refresh monitor: row order and spacing (R9), open row closed (R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            ref_gap++;
            if (mem_refresh) open_vld = 1'b0;
            if (mem_refresh && mem_ras) begin
                check(int'(mem_addr) == ref_expect, "R9 refresh row order", int'(mem_addr), ref_expect);
                check(ref_gap <= REF_IV + 8, "R9 refresh spacing", ref_gap, REF_IV + 8);
                ref_expect = (ref_expect + 1) % 4;
                ref_gap = 0;
                ref_seen++;
            end
            if (mem_ras + mem_cas + mem_pre > 1)
                check(1'b0, "R11 one strobe", mem_ras + mem_cas + mem_pre, 1);
        end
    end

    task automatic do_req(input bit we, input logic [3:0] a, input logic [7:0] d);
        int n_ras, n_cas, n_pre, order_ok, guard;
        int e_ras, e_pre;
        logic [1:0] row, col;
        row = a[3:2]; col = a[1:0];
        n_ras = 0; n_cas = 0; n_pre = 0; order_ok = 1; guard = 0;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        e_ras = (open_vld && open_row == row) ? 0 : 1;
        e_pre = (open_vld && open_row != row) ? 1 : 0;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (guard < 10) begin
            check(!req_ready, "R8 ready low while busy", req_ready, 0);
            if (mem_pre && !mem_refresh) begin
                n_pre++;
                if (n_ras != 0) order_ok = 0;
            end
            if (mem_ras && !mem_refresh) begin
                n_ras++;
                check(mem_addr == row, "R2 row on address", mem_addr, row);
            end
            if (mem_cas) begin
                n_cas++;
                if (n_ras != e_ras) order_ok = 0;
                check(mem_addr == col, "R2 column on address", mem_addr, col);
                break;
            end
            @(negedge clk);
            guard++;
        end
        if (e_pre == 1) begin
            check(n_pre == 1 && n_ras == 1 && order_ok == 1, "R5 close/open/column", n_pre*10 + n_ras, 11);
        end else if (e_ras == 1) begin
            check(n_pre == 0 && n_ras == 1, "R3 open then column", n_pre*10 + n_ras, 1);
        end else begin
            check(n_pre == 0 && n_ras == 0, "R4 page hit column only", n_pre*10 + n_ras, 0);
        end
        check(n_cas == 1, "R3 one column strobe", n_cas, 1);
        @(negedge clk);
        if (we) begin
            check(!rsp_valid, "R6 no response on write", rsp_valid, 0);
            model[a] = d;
        end else begin
            check(rsp_valid, "R6 response valid", rsp_valid, 1);
            check(rsp_rdata == model[a], "R6 R7 read data", rsp_rdata, model[a]);
        end
        open_vld = 1'b1; open_row = row;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_ras && !mem_cas && !mem_pre, "R1 reset state",
              {req_ready, rsp_valid, mem_ras, mem_cas, mem_pre}, 5'b10000);
        // R1: untouched cell reads zero; R3: closed row
        do_req(1'b0, 4'h5, 8'h00);
        // R4: same row hit, write then read
        do_req(1'b1, 4'h6, 8'hA5);
        do_req(1'b0, 4'h6, 8'h00);
        // R5 R7: switch row, then return and read the written value
        do_req(1'b0, 4'hC, 8'h00);
        do_req(1'b0, 4'h6, 8'h00);
        // R10: write, wait for a refresh, same row again must reopen
        do_req(1'b1, 4'h9, 8'h3C);
        begin
            int s;
            s = ref_seen;
            while (ref_seen == s) @(negedge clk);
            while (!req_ready) @(negedge clk);
        end
        check(open_vld == 1'b0, "R10 refresh observed closing row", open_vld, 0);
        do_req(1'b0, 4'h9, 8'h00);
        // random traffic
        for (int k = 0; k < 400; k++) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 15));
            if (($urandom % 3) == 0) a = {open_row, 2'($urandom)};
            do_req(1'($urandom), a, 8'($urandom));
        end
        check(ref_seen >= 4, "R9 all rows refreshed", ref_seen, 4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule